// File: doc/BRIEF.md
# Write Completion Status Reporter

This block sits on the read data path of a nonvolatile memory. While the internal write engine is busy with a page program or a chip erase, a read from the host does not return array contents. It returns a status byte built by the block instead. Software polls that byte to learn when the operation has ended.

Two indications are encoded in the status byte. A polling bit in position 7 carries the inverse of the most significant bit of the byte loaded last. This indication is given for programs only and is forced low during erase. A toggling bit in position 6 changes value on every read. The first read of each new operation returns 1 in this bit. When two reads in a row return the same bit 6, the operation is over.

After the engine goes idle, bit 7 carries true array data at once. The remaining bits are held at zero for a short, parameterised settling window. After that window every read returns the full array byte. A read is recognised on the rising edge of the read strobe, and the result is registered one clock later.

Top module: `poll_status_reporter`

## Requirements
- R1: While reset is high and in the cycle after it, `rd_data` is 0x00. The toggle bit is armed so that the first status read returns 1 in bit 6.
- R2: A read is a rising edge of `rd_stb` (high now, low in the previous cycle). While `wr_busy`=1 and `er_busy`=0, bit 7 of the read result equals the inverse of bit 7 of `last_byte`.
- R3: While an operation is active (`wr_busy` or `er_busy` high), bit 6 of successive read results alternates. The first read after the operation becomes active returns 1.
- R4: While `er_busy`=1, bit 7 of a read result is 0 whatever `last_byte` holds. Bit 6 still toggles.
- R5: While an operation is active, bits 5..0 of a read result are 0.
- R6: A read edge that falls in the same cycle in which the operation becomes active returns bit 6 = 1. The next read returns bit 6 = 0.
- R7: Holding `rd_stb` high for several cycles counts as one read. The toggle does not advance and `rd_data` does not change until a new rising edge.
- R8: A read taken in the first cycle with no active operation, or in the next SETTLE_CYC-1 cycles, returns bit 7 of `arr_data` with bits 6..0 at 0.
- R9: A read taken after the settling window returns `arr_data` unchanged.
- R10: `rd_data` changes only in the clock cycle after a read edge. At all other times it holds its value.
- R11: Each new operation re-arms the toggle. Its first read returns bit 6 = 1 whatever parity the previous operation ended on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_busy | input | 1 | Write engine is programming |
| er_busy | input | 1 | Chip erase in progress |
| last_byte | input | 8 | Byte loaded last before the program started |
| arr_data | input | 8 | Data read from the array |
| rd_stb | input | 1 | Read strobe; a rising edge starts one read |
| rd_data | output | 8 | Registered read result |

## Verification
Two functions can fall in the same cycle: the start of an operation and a read edge. The start re-arms the toggle, and the read consumes the toggle. The bench raises `rd_stb` in the very cycle in which `wr_busy` or `er_busy` first goes high, and expects bit 6 = 1 on that read and 0 on the next. The end of an operation can also coincide with a read. The bench drops busy in the same cycle as a read edge and expects a settling-window result, not a status byte. Random runs mix such overlaps, and every read is compared against a reference model written from the requirements.

// File: rtl/wcs_pkg.sv
package wcs_pkg;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_WRITE  = 2'd1,
        PH_ERASE  = 2'd2,
        PH_SETTLE = 2'd3
    } phase_e;

    typedef struct packed {
        logic       poll;
        logic       tog;
        logic [5:0] fill;
    } status_t;

    localparam int BYTE_W = 8;

    function automatic logic [BYTE_W-1:0] make_status(input logic erasing,
                                                      input logic last_msb,
                                                      input logic tog_bit);
        status_t s;
        s.poll = erasing ? 1'b0 : ~last_msb;
        s.tog  = tog_bit;
        s.fill = '0;
        return s;
    endfunction

    function automatic logic [BYTE_W-1:0] make_settle(input logic [BYTE_W-1:0] arr);
        logic [BYTE_W-1:0] v;
        v = '0;
        v[BYTE_W-1] = arr[BYTE_W-1];
        return v;
    endfunction

endpackage

// File: rtl/wcs_edge.sv
module wcs_edge (
    input  logic clk,
    input  logic rst,
    input  logic sig,
    output logic rise,
    output logic fall
);
    logic sig_q;

    always_ff @(posedge clk) begin
        if (rst) sig_q <= 1'b0;
        else     sig_q <= sig;
    end

    assign rise = sig & ~sig_q;
    assign fall = ~sig & sig_q;
endmodule

// File: rtl/wcs_toggle.sv
module wcs_toggle (
    input  logic clk,
    input  logic rst,
    input  logic op_start,
    input  logic op_active,
    input  logic rd_edge,
    output logic tog_now
);
    logic tgl_q;

    assign tog_now = op_start ? 1'b1 : tgl_q;

    always_ff @(posedge clk) begin
        if (rst)
            tgl_q <= 1'b1;
        else if (op_start)
            tgl_q <= rd_edge ? 1'b0 : 1'b1;
        else if (op_active && rd_edge)
            tgl_q <= ~tgl_q;
    end
endmodule

// File: rtl/wcs_settle.sv
module wcs_settle #(
    parameter int SETTLE_CYC = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic op_start,
    input  logic op_end,
    output logic settling
);
    localparam int CW = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC) : 1;
    localparam logic [CW-1:0] LOAD = CW'(SETTLE_CYC - 1);

    logic [CW-1:0] cnt_q;

    assign settling = op_end | (cnt_q != '0);

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (op_start)
            cnt_q <= '0;
        else if (op_end)
            cnt_q <= LOAD;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end
endmodule

// File: rtl/poll_status_reporter.sv
module poll_status_reporter
    import wcs_pkg::*;
#(
    parameter int SETTLE_CYC = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_busy,
    input  logic        er_busy,
    input  logic [7:0]  last_byte,
    input  logic [7:0]  arr_data,
    input  logic        rd_stb,
    output logic [7:0]  rd_data
);
    logic   active;
    logic   op_start, op_end;
    logic   rd_edge, rd_fall_unused;
    logic   tog_now;
    logic   settling;
    phase_e phase;
    logic [7:0] next_byte;
    logic [7:0] rd_q;

    assign active = wr_busy | er_busy;

    wcs_edge u_act_edge (
        .clk (clk), .rst (rst), .sig (active),
        .rise(op_start), .fall(op_end)
    );

    wcs_edge u_rd_edge (
        .clk (clk), .rst (rst), .sig (rd_stb),
        .rise(rd_edge), .fall(rd_fall_unused)
    );

    wcs_toggle u_toggle (
        .clk      (clk),
        .rst      (rst),
        .op_start (op_start),
        .op_active(active),
        .rd_edge  (rd_edge),
        .tog_now  (tog_now)
    );

    wcs_settle #(.SETTLE_CYC(SETTLE_CYC)) u_settle (
        .clk     (clk),
        .rst     (rst),
        .op_start(op_start),
        .op_end  (op_end),
        .settling(settling)
    );

    always_comb begin
        if (er_busy)       phase = PH_ERASE;
        else if (wr_busy)  phase = PH_WRITE;
        else if (settling) phase = PH_SETTLE;
        else               phase = PH_IDLE;
    end

    always_comb begin
        unique case (phase)
            PH_ERASE:  next_byte = make_status(1'b1, last_byte[7], tog_now);
            PH_WRITE:  next_byte = make_status(1'b0, last_byte[7], tog_now);
            PH_SETTLE: next_byte = make_settle(arr_data);
            default:   next_byte = arr_data;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)          rd_q <= '0;
        else if (rd_edge) rd_q <= next_byte;
    end

    assign rd_data = rd_q;
endmodule

// File: rtl/poll_status_reporter_chk.sv
module poll_status_reporter_chk (
    input logic       clk,
    input logic       rst,
    input logic       wr_busy,
    input logic       er_busy,
    input logic [7:0] last_byte,
    input logic       rd_stb,
    input logic [7:0] rd_data
);
    logic stb_prev;
    logic rd_ev;

    always_ff @(posedge clk) begin
        if (rst) stb_prev <= 1'b0;
        else     stb_prev <= rd_stb;
    end

    assign rd_ev = rd_stb & ~stb_prev;

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (rd_data == 8'h00));

    assert_poll_inverse_R2: assert property (@(posedge clk) disable iff (rst)
        (rd_ev && wr_busy && !er_busy) |=> (rd_data[7] == ~$past(last_byte[7])));

    assert_erase_poll_low_R4: assert property (@(posedge clk) disable iff (rst)
        (rd_ev && er_busy) |=> (rd_data[7] == 1'b0));

    assert_fill_zero_R5: assert property (@(posedge clk) disable iff (rst)
        (rd_ev && (wr_busy || er_busy)) |=> (rd_data[5:0] == 6'd0));

    assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (!rd_ev && !rst) |=> $stable(rd_data));
endmodule

bind poll_status_reporter poll_status_reporter_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .wr_busy  (wr_busy),
    .er_busy  (er_busy),
    .last_byte(last_byte),
    .rd_stb   (rd_stb),
    .rd_data  (rd_data)
);

// File: tb/test_poll_status_reporter.sv
`timescale 1ns/1ps
module test_poll_status_reporter;
    localparam int S = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_busy = 1'b0, er_busy = 1'b0, rd_stb = 1'b0;
    logic [7:0] last_byte = 8'h00, arr_data = 8'h00;
    logic [7:0] rd_data;

    int n_run = 0, n_fail = 0;

    logic       m_stb = 1'b0, m_act = 1'b0, m_tgl = 1'b1;
    int         m_cnt = 0;
    logic [7:0] m_exp = 8'h00;

    always #5 clk = ~clk;

    poll_status_reporter #(.SETTLE_CYC(S)) i_poll_status_reporter (
        .clk(clk), .rst(rst), .wr_busy(wr_busy), .er_busy(er_busy),
        .last_byte(last_byte), .arr_data(arr_data), .rd_stb(rd_stb),
        .rd_data(rd_data)
    );

    function automatic logic [7:0] status_ref(input logic er, input logic [7:0] lb,
                                              input logic t);
        return {(er ? 1'b0 : ~lb[7]), t, 6'b0};
    endfunction

    task automatic model_step();
        logic act, rise, fall, edg, settl;
        act   = wr_busy | er_busy;
        rise  = act & ~m_act;
        fall  = ~act & m_act;
        edg   = rd_stb & ~m_stb;
        settl = fall | (m_cnt != 0);
        if (rst) begin
            m_exp = 8'h00; m_tgl = 1'b1; m_cnt = 0; m_stb = 1'b0; m_act = 1'b0;
        end else begin
            if (edg) begin
                if (act)        m_exp = status_ref(er_busy, last_byte, rise ? 1'b1 : m_tgl);
                else if (settl) m_exp = {arr_data[7], 7'b0};
                else            m_exp = arr_data;
            end
            if (rise)              m_tgl = edg ? 1'b0 : 1'b1;
            else if (act && edg)   m_tgl = ~m_tgl;
            if (act)               m_cnt = 0;
            else if (fall)         m_cnt = S - 1;
            else if (m_cnt != 0)   m_cnt = m_cnt - 1;
            m_stb = rd_stb;
            m_act = act;
        end
    endtask

    task automatic check(input string tag, input logic [7:0] exp);
        n_run++;
        if (rd_data !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%02h expected=%02h", tag, rd_data, exp);
        end
    endtask

    // apply inputs at negedge, model after posedge, compare mid-cycle
    task automatic cyc(input logic b, input logic e, input logic s,
                       input logic [7:0] lb, input logic [7:0] ar, input string tag);
        wr_busy = b; er_busy = e; rd_stb = s; last_byte = lb; arr_data = ar;
        @(posedge clk);
        model_step();
        #2;
        check(tag, m_exp);
        @(negedge clk);
    endtask

    task automatic rd(input logic b, input logic e, input logic [7:0] lb,
                      input logic [7:0] ar, input string tag);
        cyc(b, e, 1'b0, lb, ar, tag);
        cyc(b, e, 1'b1, lb, ar, tag);
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        @(negedge clk);
        rst = 1'b1;
        repeat (3) begin
            @(posedge clk); model_step(); #2; check("R1 reset", 8'h00); @(negedge clk);
        end
        rst = 1'b0;
        cyc(0, 0, 0, 8'h00, 8'h5A, "R1 after reset");
        check("R1 post reset value", 8'h00);

        // idle read: full array data
        rd(0, 0, 8'h00, 8'hC3, "R9 idle read");
        check("R9 idle explicit", 8'hC3);

        // write: start then reads
        cyc(1, 0, 0, 8'h80, 8'h11, "R10 start no read");
        check("R10 held", 8'hC3);
        rd(1, 0, 8'h80, 8'h11, "R2 first read");
        check("R3 first read bit6=1", 8'h40);
        rd(1, 0, 8'h80, 8'h11, "R3 second read");
        check("R3 second read bit6=0", 8'h00);
        cyc(1, 0, 1, 8'h80, 8'h11, "R7 held strobe");
        cyc(1, 0, 1, 8'h80, 8'h11, "R7 held strobe");
        check("R7 held no change", 8'h00);
        rd(1, 0, 8'h80, 8'h11, "R3 third read");
        check("R3 third read", 8'h40);
        rd(1, 0, 8'h00, 8'h11, "R2 msb0");
        check("R2 inverse of 0", 8'h80);
        // end: read in fall cycle -> settle
        cyc(1, 0, 0, 8'h00, 8'hF5, "R8 pre");
        cyc(0, 0, 1, 8'h00, 8'hF5, "R8 fall cycle read");
        check("R8 settle value", 8'h80);
        rd(0, 0, 8'h00, 8'hF5, "R8 inside window");
        check("R8 inside window", 8'h80);
        repeat (S) cyc(0, 0, 0, 8'h00, 8'hF5, "R10 idle");
        rd(0, 0, 8'h00, 8'hF5, "R9 after window");
        check("R9 after window", 8'hF5);

        // erase with coincident start and read
        cyc(0, 0, 0, 8'h00, 8'h00, "R10 idle");
        cyc(0, 1, 1, 8'h00, 8'h00, "R6 start+read");
        check("R6 R4 start read", 8'h40);
        rd(0, 1, 8'h00, 8'h00, "R6 next read");
        check("R6 next bit6=0", 8'h00);
        rd(0, 1, 8'h7F, 8'h00, "R4 erase poll low");
        check("R4 erase bit7=0", 8'h40);
        cyc(0, 1, 0, 8'h7F, 8'h00, "R10 idle");
        // ends after odd count; new write re-arms
        cyc(0, 0, 0, 8'h00, 8'h3C, "R10 gap");
        cyc(1, 0, 0, 8'h00, 8'h3C, "R11 new op");
        rd(1, 0, 8'h00, 8'h3C, "R11 rearm");
        check("R11 first read of new op", 8'hC0);
        cyc(1, 0, 0, 8'h00, 8'h3C, "R5 hold");
        cyc(0, 0, 0, 8'h00, 8'h3C, "R10 end");

        // random mix
        for (int i = 0; i < 4000; i++) begin
            logic b, e, s;
            int   r;
            r = $urandom(i == 0 ? 32'd77 : 32'd0) % 100;
            r = $urandom % 100;
            b = (i / 40) % 3 == 1;
            e = (i / 40) % 3 == 2 && (r < 97);
            s = ($urandom % 3) != 0;
            cyc(b, e, s, 8'($urandom), 8'($urandom), "R3 R5 R8 random");
        end

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule